// File: doc/BRIEF.md
# Pulse Dialing Waveform Generator

This block produces the line-break waveform of a loop-disconnect (pulse) telephone dialer. A keypad controller or a redial sequencer hands it one request at a time over a valid/ready handshake. A request is either a decimal digit or a flash with one of four break lengths. For a digit, the block raises the mute outputs and waits a short pre-digit gap. It then opens the line once per pulse at 10 pulses per second, and finally holds an 800 ms inter-digit gap before it takes the next request. For a flash, it opens the line for the selected time and then holds a 1 s recovery pause.

All timing is counted in ticks of an external 1 ms strobe. A phase that lasts N ms covers exactly N tick pulses after it is entered. A ratio-select input chooses between 40:60 and 33:67 make:break timing, and the value is captured when a digit is accepted. The busy flag covers the whole job, from acceptance to the end of the trailing gap, so the keypad logic can use it as a lockout.

Top module: `pdial_top`

## Requirements
- R1: After reset, busy_o is 0, req_ready_o is 1, break_o is 0, pulse_mute_o is 0 and tp_mute_no is 1.
- R2: req_ready_o is always the inverse of busy_o. A request is taken only on a clock edge where req_valid_i and req_ready_o are both 1. A request raised while busy has no effect on the outputs, either during the current job or after it.
- R3: With req_flash_i at 0, req_code_i values 1 to 9 produce that many line breaks, and value 0 produces 10.
- R4: With ratio_sel_i at 0, each break lasts 60 ticks and each make lasts 40 ticks. With ratio_sel_i at 1, they last 67 and 33 ticks.
- R5: Between acceptance of a digit and its first break there is a pre-digit gap with the mutes active and the line closed. The gap is 40 ticks at ratio 0 and 33 ticks at ratio 1.
- R6: After the make that follows the last break of a digit, the block stays busy for 800 ticks with the line closed and the mutes inactive. It then returns to idle.
- R7: pulse_mute_o is 1 and tp_mute_no is 0 for the whole period from acceptance to the end of the last make, and for the whole of a flash break. At all other times pulse_mute_o is 0 and tp_mute_no is 1.
- R8: With req_flash_i at 1, req_code_i[1:0] selects one break: 0 gives 600 ticks, 1 gives 300, 2 gives 73 and 3 gives 100.
- R9: A flash break is followed by 1000 ticks of busy with the line closed and the mutes inactive. The block is then idle.
- R10: The ratio is sampled when a digit is accepted. Changes to ratio_sel_i during the digit have no effect on its timing.
- R11: With req_flash_i at 0, req_code_i values 10 to 15 are accepted and dropped. They produce no break, no mute and no busy.
- R12: Every duration is counted in tick_i pulses. A phase of N ticks covers exactly the N ticks seen after its entry edge, and a tick that falls on the acceptance edge is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle strobe every 1 ms |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_flash_i | input | 1 | 1 = flash request, 0 = digit |
| req_code_i | input | 4 | Digit value, or break selection in bits [1:0] |
| ratio_sel_i | input | 1 | 0 = 40:60, 1 = 33:67 make:break |
| break_o | output | 1 | Line break drive, 1 = line open |
| pulse_mute_o | output | 1 | Pulse mute, active high |
| tp_mute_no | output | 1 | Tone/pulse mute, active low |
| busy_o | output | 1 | Job in progress, keypad lockout |

## Verification
The embedded assertions check the following on every cycle:
- the line is never open without the mutes;
- a valid accepted request always makes the block busy;
- the captured ratio never moves during a job;
- no timed phase is ever loaded with or left at a zero count;
- the pulse counter is never decremented past its final pulse.

Only the directed scenarios can show the rest, because those properties depend on whole phases:
- the exact tick lengths of each phase for both ratios;
- the pulse count for each digit, including the ten breaks of digit 0;
- the four flash lengths and the recovery pause;
- that ratio changes and requests raised mid-job leave no trace.

// File: rtl/pdial_pkg.sv
package pdial_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_BRK, ST_MAKE, ST_IDP, ST_FBRK, ST_FPAUSE
  } dial_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pdial_timer.sv
module pdial_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = tick_i && (cnt_q == CNT_W'(1));

  AST_LOAD_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> load_val_i != '0); // R12
endmodule

// File: rtl/pdial_pulse_cnt.sv
module pdial_pulse_cnt #(
  parameter int unsigned PC_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PC_W-1:0] load_val_i,
  input  logic            dec_i,
  output logic            last_o
);
  logic [PC_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rem_q <= '0;
    else if (load_i) rem_q <= load_val_i;
    else if (dec_i)  rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == PC_W'(1));

  AST_NO_PULSE_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> rem_q > PC_W'(1)); // R3
endmodule

// File: rtl/pdial_fsm.sv
module pdial_fsm
  import pdial_pkg::*;
#(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned PC_W        = 4,
  parameter int unsigned PRE_A       = 40,
  parameter int unsigned MAKE_A      = 40,
  parameter int unsigned BRK_A       = 60,
  parameter int unsigned PRE_B       = 33,
  parameter int unsigned MAKE_B      = 33,
  parameter int unsigned BRK_B       = 67,
  parameter int unsigned IDP_T       = 800,
  parameter int unsigned FPAUSE_T    = 1000,
  parameter int unsigned ZERO_PULSES = 10,
  parameter int unsigned FLASH_T [4] = '{600, 300, 73, 100}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_flash_i,
  input  logic [3:0]       req_code_i,
  input  logic             ratio_sel_i,
  input  logic             tmr_done_i,
  input  logic             last_pulse_i,
  output logic             tmr_load_o,
  output logic [CNT_W-1:0] tmr_val_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_val_o,
  output logic             pc_dec_o,
  output dial_state_e      state_o,
  output logic             ratio_o
);
  dial_state_e state_q, state_d;
  logic ratio_q, ratio_d;
  logic [CNT_W-1:0] brk_len, make_len;

  assign brk_len  = ratio_q ? CNT_W'(BRK_B)  : CNT_W'(BRK_A);
  assign make_len = ratio_q ? CNT_W'(MAKE_B) : CNT_W'(MAKE_A);

  always_comb begin
    state_d    = state_q;
    ratio_d    = ratio_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    pc_load_o  = 1'b0;
    pc_val_o   = '0;
    pc_dec_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        if (req_flash_i) begin
          state_d    = ST_FBRK;
          tmr_load_o = 1'b1;
          tmr_val_o  = CNT_W'(FLASH_T[req_code_i[1:0]]);
        end else if (req_code_i <= 4'd9) begin
          state_d    = ST_PRE;
          ratio_d    = ratio_sel_i;
          tmr_load_o = 1'b1;
          tmr_val_o  = ratio_sel_i ? CNT_W'(PRE_B) : CNT_W'(PRE_A);
          pc_load_o  = 1'b1;
          pc_val_o   = (req_code_i == 4'd0) ? PC_W'(ZERO_PULSES) : PC_W'(req_code_i);
        end
      end
      ST_PRE: if (tmr_done_i) begin
        state_d = ST_BRK; tmr_load_o = 1'b1; tmr_val_o = brk_len;
      end
      ST_BRK: if (tmr_done_i) begin
        state_d = ST_MAKE; tmr_load_o = 1'b1; tmr_val_o = make_len;
      end
      ST_MAKE: if (tmr_done_i) begin
        tmr_load_o = 1'b1;
        if (last_pulse_i) begin
          state_d = ST_IDP; tmr_val_o = CNT_W'(IDP_T);
        end else begin
          state_d = ST_BRK; tmr_val_o = brk_len; pc_dec_o = 1'b1;
        end
      end
      ST_FBRK: if (tmr_done_i) begin
        state_d = ST_FPAUSE; tmr_load_o = 1'b1; tmr_val_o = CNT_W'(FPAUSE_T);
      end
      ST_IDP, ST_FPAUSE: if (tmr_done_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ratio_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
    end
  end

  assign state_o = state_q;
  assign ratio_o = ratio_q;
endmodule

// File: rtl/pdial_top.sv
module pdial_top
  import pdial_pkg::*;
#(
  parameter int unsigned PRE_A       = 40,
  parameter int unsigned MAKE_A      = 40,
  parameter int unsigned BRK_A       = 60,
  parameter int unsigned PRE_B       = 33,
  parameter int unsigned MAKE_B      = 33,
  parameter int unsigned BRK_B       = 67,
  parameter int unsigned IDP_T       = 800,
  parameter int unsigned FPAUSE_T    = 1000,
  parameter int unsigned ZERO_PULSES = 10,
  parameter int unsigned FLASH_T [4] = '{600, 300, 73, 100}
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_valid_i,
  output logic       req_ready_o,
  input  logic       req_flash_i,
  input  logic [3:0] req_code_i,
  input  logic       ratio_sel_i,
  output logic       break_o,
  output logic       pulse_mute_o,
  output logic       tp_mute_no,
  output logic       busy_o
);
  localparam int unsigned FL_MAX = max2(max2(FLASH_T[0], FLASH_T[1]), max2(FLASH_T[2], FLASH_T[3]));
  localparam int unsigned T_MAX  = max2(max2(max2(IDP_T, FPAUSE_T), FL_MAX),
                                        max2(max2(BRK_A, BRK_B), max2(PRE_A, PRE_B)));
  localparam int unsigned CNT_W  = $clog2(T_MAX + 1);
  localparam int unsigned PC_W   = $clog2(max2(ZERO_PULSES, 9) + 1);

  logic             tmr_load, tmr_done, pc_load, pc_dec, last_pulse, ratio_q, mute;
  logic [CNT_W-1:0] tmr_val, tmr_cnt;
  logic [PC_W-1:0]  pc_val;
  dial_state_e      state;

  pdial_fsm #(
    .CNT_W(CNT_W), .PC_W(PC_W),
    .PRE_A(PRE_A), .MAKE_A(MAKE_A), .BRK_A(BRK_A),
    .PRE_B(PRE_B), .MAKE_B(MAKE_B), .BRK_B(BRK_B),
    .IDP_T(IDP_T), .FPAUSE_T(FPAUSE_T), .ZERO_PULSES(ZERO_PULSES), .FLASH_T(FLASH_T)
  ) u_fsm (
    .clk_i, .rst_ni,
    .req_valid_i (req_valid_i && req_ready_o),
    .req_flash_i, .req_code_i, .ratio_sel_i,
    .tmr_done_i  (tmr_done),
    .last_pulse_i(last_pulse),
    .tmr_load_o  (tmr_load),
    .tmr_val_o   (tmr_val),
    .pc_load_o   (pc_load),
    .pc_val_o    (pc_val),
    .pc_dec_o    (pc_dec),
    .state_o     (state),
    .ratio_o     (ratio_q)
  );

  pdial_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .tick_i,
    .load_i(tmr_load), .load_val_i(tmr_val),
    .cnt_o(tmr_cnt), .done_o(tmr_done)
  );

  pdial_pulse_cnt #(.PC_W(PC_W)) u_pcnt (
    .clk_i, .rst_ni,
    .load_i(pc_load), .load_val_i(pc_val), .dec_i(pc_dec), .last_o(last_pulse)
  );

  assign break_o      = (state == ST_BRK) || (state == ST_FBRK);
  assign mute         = (state == ST_PRE) || (state == ST_BRK) ||
                        (state == ST_MAKE) || (state == ST_FBRK);
  assign pulse_mute_o = mute;
  assign tp_mute_no   = ~mute;
  assign busy_o       = (state != ST_IDLE);
  assign req_ready_o  = ~busy_o;

  AST_BREAK_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_o |-> pulse_mute_o); // R7
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && (req_flash_i || req_code_i <= 4'd9)) |=> busy_o); // R2
  AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ratio_q)); // R10
  AST_TIMER_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> tmr_cnt != '0); // R12
endmodule

// File: tb/pdial_top_tb.sv
module pdial_top_tb;
  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic req_valid_i = 1'b0, req_flash_i = 1'b0, ratio_sel_i = 1'b0;
  logic [3:0] req_code_i = '0;
  logic req_ready_o, break_o, pulse_mute_o, tp_mute_no, busy_o;

  int n_chk = 0, n_fail = 0;
  int m_pre, m_brk, m_make, m_idp, m_pulses, m_bad;
  int div = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    div    <= (div == 3) ? 0 : div + 1;
    tick_i <= (div == 3);
  end

  pdial_top u_dut (
    .clk_i(clk), .rst_ni, .tick_i, .req_valid_i, .req_ready_o, .req_flash_i,
    .req_code_i, .ratio_sel_i, .break_o, .pulse_mute_o, .tp_mute_no, .busy_o
  );

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic send(bit fl, logic [3:0] code);
    @(negedge clk);
    req_flash_i = fl; req_code_i = code; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic measure(bit flip, bit inject);
    bit prev = 1'b0;
    m_pre = 0; m_brk = 0; m_make = 0; m_idp = 0; m_pulses = 0; m_bad = 0;
    while (busy_o) begin
      if (tp_mute_no !== ~pulse_mute_o) m_bad++;
      if (req_ready_o !== ~busy_o) m_bad++;
      if (tick_i) begin
        if (break_o) begin
          m_brk++;
          if (!prev) m_pulses++;
        end else if (pulse_mute_o) begin
          if (m_pulses == 0) m_pre++; else m_make++;
        end else m_idp++;
        prev = break_o;
        if (flip && m_brk == 1) ratio_sel_i = ~ratio_sel_i;
        if (inject && m_brk == 10) begin
          req_flash_i = 1'b0; req_code_i = 4'd5; req_valid_i = 1'b1;
        end
        if (inject && m_brk == 20) req_valid_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic quiet(string r);
    int hits = 0;
    repeat (200) begin
      @(negedge clk);
      if (break_o || busy_o || pulse_mute_o || !tp_mute_no) hits++;
    end
    chk(r, hits, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 ready", req_ready_o, 1);
    chk("R1 break", break_o, 0);
    chk("R1 pulse_mute", pulse_mute_o, 0);
    chk("R1 tp_mute_n", tp_mute_no, 1);
  endtask

  task automatic t_digit(logic [3:0] code, bit ratio, bit flip);
    int n = (code == 0) ? 10 : int'(code);
    int p = ratio ? 33 : 40;
    int b = ratio ? 67 : 60;
    int m = ratio ? 33 : 40;
    ratio_sel_i = ratio;
    send(1'b0, code);
    measure(flip, 1'b0);
    chk("R3 pulse count", m_pulses, n);
    chk("R5 pre-digit ticks", m_pre, p);
    chk(flip ? "R10 break ticks" : "R4 R12 break ticks", m_brk, n * b);
    chk(flip ? "R10 make ticks" : "R4 make ticks", m_make, n * m);
    chk("R6 inter-digit ticks", m_idp, 800);
    chk("R7 R2 mute/ready consistency", m_bad, 0);
    ratio_sel_i = 1'b0;
  endtask

  task automatic t_flash(logic [1:0] sel, int len, bit inject);
    send(1'b1, {2'b00, sel});
    measure(1'b0, inject);
    chk("R8 flash break ticks", m_brk, len);
    chk("R8 single break", m_pulses, 1);
    chk("R9 flash pause ticks", m_idp, 1000);
    chk("R7 no mute outside break", m_pre + m_make, 0);
    if (inject) quiet("R2 request while busy ignored");
  endtask

  task automatic t_bad_code();
    send(1'b0, 4'd12);
    quiet("R11 code 12 dropped");
    send(1'b0, 4'd15);
    quiet("R11 code 15 dropped");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_digit(4'd1, 1'b0, 1'b0);
    t_digit(4'd5, 1'b0, 1'b0);
    t_digit(4'd0, 1'b0, 1'b0);
    t_digit(4'd3, 1'b1, 1'b0);
    t_digit(4'd0, 1'b1, 1'b1);
    t_digit(4'd2, 1'b0, 1'b1);
    t_flash(2'd0, 600, 1'b1);
    t_flash(2'd1, 300, 1'b0);
    t_flash(2'd2, 73, 1'b1);
    t_flash(2'd3, 100, 1'b0);
    t_bad_code();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule